// File: doc/BRIEF.md
# Two-Queue Contention Router for a 2x2 Switch Stage

This block is the routing core of one 2x2 switching element in a multistage cell network. Each slot (one clock cycle) it accepts up to two cells from the input side. Every cell carries an identifier, a one-bit priority, a routing tag, a broadcast flag, a multicast flag and a short list of multicast destination addresses. The block picks the upper side, the lower side or both for each cell. It places each copy on one of four lanes: a primary and a spare lane per side. The lane decisions appear registered one cycle after the slot.

When two cells want the same side, the high-priority cell takes that side's primary lane. The other cell takes the spare lane if the spare can be used. Otherwise the losing copy is parked in one of two shared FIFO queues. Each queue fill stays on one queue until it is full. Each drain stays on one queue until it is empty. Both policies start with the upper queue. While any cell is parked, the block routes one parked cell per slot and stores all new arrivals behind it, so cells leave in the order they arrived. Per-lane fault flags steer copies away from broken lanes. A pulse on the loss output marks any copy that could not be placed or stored.

Top module: `rtr_contention_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every lane is invalid and the loss output is low.
- R2: Lanes are numbered bit 0 upper primary, bit 1 lower primary, bit 2 upper spare, bit 3 lower spare, and the fault flags use the same numbering. A unicast cell at stage s reads tag bit TAG_W-1-s: 0 selects the upper side and 1 the lower side. The result appears on the lanes in the cycle after the slot.
- R3: When two cells contend for one side with different priorities (in_hi=1 is high) and both of that side's lanes are healthy, the high-priority cell goes to the primary lane and the other cell to the spare lane.
- R4: When two contending cells have equal priority, the cell on port 0 wins.
- R5: The losing copy is stored in a queue instead of the spare lane when either lane of that side is faulty. A stored entry keeps the identifier and priority and only the sides that copy lost.
- R6: While either queue holds a cell, each slot routes exactly one queued head cell. All valid arrivals that have at least one destination are stored, port 0 before port 1, and do not appear on any lane in that slot.
- R7: Stores go to the current target queue, which starts as the upper queue. A store switches to the other queue only when the target is full, and that queue then becomes the target.
- R8: Reads take from the current read queue, which starts as the upper queue. Reads switch to the other queue only when the current one is empty.
- R9: A cell that must be stored while both queues are full is discarded, and out_lost pulses in the cycle after the slot.
- R10: A copy whose primary lane is faulty goes to that side's spare lane. A copy with both lanes of its side faulty is discarded with an out_lost pulse. A faulty lane is never valid in the following cycle.
- R11: A broadcast cell is sent to both sides at every stage other than 0. At stage 0 it is routed by its tag. Broadcast takes precedence over multicast.
- R12: A multicast cell examines this stage's bit in the first in_mcnt addresses of its list. It goes to the upper side if any of those bits is 0 and to the lower side if any is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 2 | Cell present, one bit per input port |
| in_hi | input | 2 | Cell priority, 1 = high |
| in_bc | input | 2 | Broadcast flag per port |
| in_mc | input | 2 | Multicast flag per port |
| in_id | input | 2*ID_W | Cell identifier, port p at bits p*ID_W upward |
| in_tag | input | 2*TAG_W | Routing tag, port p at bits p*TAG_W upward |
| in_mcnt | input | 2*CNT_W | Number of listed multicast addresses per port |
| in_mlist | input | 2*MC_N*TAG_W | Multicast addresses, entry k of port p at (p*MC_N+k)*TAG_W |
| lane_flt | input | 4 | Lane fault flags, numbered as the lanes |
| out_vld | output | 4 | Lane carries a cell |
| out_hi | output | 4 | Priority of the cell on each lane |
| out_id | output | 4*ID_W | Identifier per lane, lane i at bits i*ID_W upward |
| out_lost | output | 1 | One or more copies discarded in the previous slot |

## Verification
The bench first uses single cells on each tag value to separate side selection from arbitration. It then uses paired cells on one side with unequal and equal priorities, which shows whether priority or port order decides the primary lane. Fault patterns on a primary lane, on a spare lane and on both lanes of a side separate redirection, deferral and discard. A long run of paired arrivals with the spares faulty fills the upper queue, then the lower queue, then overflows, and the drain that follows exposes any error in store or read order. Broadcast and multicast cells with lists that agree or disagree on the stage bit check each replication decision. A long mixed random run with occasional faults is also compared slot by slot against a behavioural queue model.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NUM_SIDES = 2;
  localparam int NUM_LANES = 4;
  typedef enum logic {Q_UPPER = 1'b0, Q_LOWER = 1'b1} qsel_e;
endpackage

// File: rtl/rtr_dest.sv
module rtr_dest #(
  parameter int MC_N  = 2,
  parameter int CNT_W = 2,
  parameter bit REPL  = 1'b1
) (
  input  logic             bc,
  input  logic             mc,
  input  logic             tag_bit,
  input  logic [CNT_W-1:0] mcnt,
  input  logic [MC_N-1:0]  mbits,
  output logic [1:0]       want
);
  logic [MC_N-1:0] listed;

  for (genvar k = 0; k < MC_N; k++) begin : g_listed
    assign listed[k] = (mcnt > CNT_W'(k));
  end

  // want[0] = upper side, want[1] = lower side
  always_comb begin
    if (bc && REPL) begin
      want = 2'b11;
    end else if (mc) begin
      want = {|(listed & mbits), |(listed & ~mbits)};
    end else begin
      want = {tag_bit, ~tag_bit};
    end
  end
endmodule

// File: rtl/rtr_side_arb.sv
module rtr_side_arb (
  input  logic [1:0] req,
  input  logic [1:0] hi,
  input  logic       pri_ok,
  input  logic       spr_ok,
  output logic       pri_v,
  output logic       pri_src,
  output logic       spr_v,
  output logic       spr_src,
  output logic [1:0] defer,
  output logic       drop
);
  logic both, win;

  always_comb begin
    both    = &req;
    win     = both ? (hi[1] & ~hi[0]) : req[1];
    pri_v   = 1'b0;
    spr_v   = 1'b0;
    pri_src = win;
    spr_src = win;
    defer   = 2'b00;
    drop    = 1'b0;
    if (|req) begin
      if (pri_ok)      pri_v = 1'b1;
      else if (spr_ok) spr_v = 1'b1;
      else             drop  = 1'b1;
    end
    if (both) begin
      if (pri_ok && spr_ok) begin
        spr_v   = 1'b1;
        spr_src = ~win;
      end else begin
        defer[~win] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic [W-1:0]  din_a,
  input  logic          wr_b,
  input  logic [W-1:0]  din_b,
  input  logic          rd,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, wp_b, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, empty_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_b  = wr_a ? step(wp_q) : wp_q;
    wp_d  = wp_q;
    if (wr_a) wp_d = wp_b;
    if (wr_b) wp_d = step(wp_b);
    rp_d  = rd ? step(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(wr_a) + CW'(wr_b) - CW'(rd);
  end

  always_ff @(posedge clk) begin
    if (wr_a) mem[wp_q] <= din_a;
    if (wr_b) mem[wp_b] <= din_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CW'(DEPTH));
      empty_q <= (cnt_d == '0);
    end
  end

  assign head  = mem[rp_q];
  assign cnt   = cnt_q;
  assign full  = full_q;
  assign empty = empty_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a || wr_b) |-> (int'(cnt_q) + int'(wr_a) + int'(wr_b)) <= DEPTH);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty_q);
  // R7
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |-> wr_a);
endmodule

// File: rtl/rtr_contention_core.sv
module rtr_contention_core
  import rtr_pkg::*;
#(
  parameter int STAGE  = 1,
  parameter int TAG_W  = 3,
  parameter int ID_W   = 8,
  parameter int DEPTH  = 4,
  parameter int MC_N   = 2,
  localparam int CNT_W = $clog2(MC_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              in_vld,
  input  logic [1:0]              in_hi,
  input  logic [1:0]              in_bc,
  input  logic [1:0]              in_mc,
  input  logic [2*ID_W-1:0]       in_id,
  input  logic [2*TAG_W-1:0]      in_tag,
  input  logic [2*CNT_W-1:0]      in_mcnt,
  input  logic [2*MC_N*TAG_W-1:0] in_mlist,
  input  logic [3:0]              lane_flt,
  output logic [3:0]              out_vld,
  output logic [3:0]              out_hi,
  output logic [4*ID_W-1:0]       out_id,
  output logic                    out_lost
);
  localparam int BIT  = TAG_W - 1 - STAGE;
  localparam bit REPL = (STAGE != 0);
  localparam int EW   = ID_W + 3;
  localparam int CW   = $clog2(DEPTH + 1);

  logic            unused_bits;
  logic [1:0]      want_raw [2];
  logic [1:0]      want     [2];

  logic            q_wa [2], q_wb [2], q_rd [2], q_full [2], q_empty [2];
  logic [EW-1:0]   q_da [2], q_db [2], q_head [2];
  logic [CW-1:0]   q_cnt [2];

  logic            q_any, pop_sel, rs_q, rs_d, ws_q, ws_d, ovf;
  logic [ID_W-1:0] src_id [2];
  logic            src_hi [2];
  logic [1:0]      src_m  [2];

  logic [1:0]      arb_req [2];
  logic            pri_v [2], pri_src [2], spr_v [2], spr_src [2], drop [2];
  logic [1:0]      defer [2];
  logic [1:0]      left  [2];
  logic            cand_v [2];
  logic [EW-1:0]   cand_e [2];

  logic [3:0]        lane_v_d, lane_hi_d, out_vld_q, out_hi_q;
  logic [4*ID_W-1:0] lane_id_d, out_id_q;
  logic              lost_q;

  assign unused_bits = ^{in_tag, in_mlist};

  // destination decode per input port
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [MC_N-1:0] mb;
    for (genvar k = 0; k < MC_N; k++) begin : g_mb
      assign mb[k] = in_mlist[(p*MC_N + k)*TAG_W + BIT];
    end
    rtr_dest #(.MC_N(MC_N), .CNT_W(CNT_W), .REPL(REPL)) u_dest (
      .bc     (in_bc[p]),
      .mc     (in_mc[p]),
      .tag_bit(in_tag[p*TAG_W + BIT]),
      .mcnt   (in_mcnt[p*CNT_W +: CNT_W]),
      .mbits  (mb),
      .want   (want_raw[p])
    );
    assign want[p] = in_vld[p] ? want_raw[p] : 2'b00;
  end

  // shared queues
  for (genvar q = 0; q < 2; q++) begin : g_q
    rtr_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_a (q_wa[q]),
      .din_a(q_da[q]),
      .wr_b (q_wb[q]),
      .din_b(q_db[q]),
      .rd   (q_rd[q]),
      .head (q_head[q]),
      .cnt  (q_cnt[q]),
      .full (q_full[q]),
      .empty(q_empty[q])
    );
  end

  // read side: sticky until the current queue runs dry
  always_comb begin
    q_any   = !q_empty[Q_UPPER] || !q_empty[Q_LOWER];
    pop_sel = q_empty[rs_q] ? ~rs_q : rs_q;
    rs_d    = q_any ? pop_sel : rs_q;
    q_rd[0] = q_any && (pop_sel == 1'b0);
    q_rd[1] = q_any && (pop_sel == 1'b1);
  end

  // routing sources: queued head first, arrivals only when both queues empty
  always_comb begin
    if (q_any) begin
      {src_id[0], src_hi[0], src_m[0]} = q_head[pop_sel];
      src_id[1] = '0;
      src_hi[1] = 1'b0;
      src_m[1]  = 2'b00;
    end else begin
      for (int p = 0; p < 2; p++) begin
        src_id[p] = in_id[p*ID_W +: ID_W];
        src_hi[p] = in_hi[p];
        src_m[p]  = want[p];
      end
    end
  end

  // per-side arbitration
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    assign arb_req[s] = {src_m[1][s], src_m[0][s]};
    rtr_side_arb u_arb (
      .req    (arb_req[s]),
      .hi     ({src_hi[1], src_hi[0]}),
      .pri_ok (!lane_flt[s]),
      .spr_ok (!lane_flt[s+2]),
      .pri_v  (pri_v[s]),
      .pri_src(pri_src[s]),
      .spr_v  (spr_v[s]),
      .spr_src(spr_src[s]),
      .defer  (defer[s]),
      .drop   (drop[s])
    );
    // R3
    hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_req[s] == 2'b11 && (src_hi[0] != src_hi[1]) && !lane_flt[s])
        |-> (pri_v[s] && pri_src[s] == src_hi[1]));
  end

  // lane next values
  always_comb begin
    for (int s = 0; s < NUM_SIDES; s++) begin
      lane_v_d[s]                   = pri_v[s];
      lane_hi_d[s]                  = src_hi[pri_src[s]];
      lane_id_d[s*ID_W +: ID_W]     = src_id[pri_src[s]];
      lane_v_d[s+2]                 = spr_v[s];
      lane_hi_d[s+2]                = src_hi[spr_src[s]];
      lane_id_d[(s+2)*ID_W +: ID_W] = src_id[spr_src[s]];
    end
  end

  // store candidates
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      left[p] = {defer[1][p], defer[0][p]};
      if (q_any) begin
        cand_v[p] = |want[p];
        cand_e[p] = {in_id[p*ID_W +: ID_W], in_hi[p], want[p]};
      end else begin
        cand_v[p] = |left[p];
        cand_e[p] = {src_id[p], src_hi[p], left[p]};
      end
    end
  end

  // store side: sticky until the target queue is full
  always_comb begin : store_sel
    int   fill [2];
    logic tgt;
    logic ok;
    ws_d    = ws_q;
    ovf     = 1'b0;
    fill[0] = int'(q_cnt[0]);
    fill[1] = int'(q_cnt[1]);
    for (int q = 0; q < 2; q++) begin
      q_wa[q] = 1'b0;
      q_wb[q] = 1'b0;
      q_da[q] = '0;
      q_db[q] = '0;
    end
    for (int p = 0; p < 2; p++) begin
      tgt = ws_d;
      ok  = 1'b0;
      if (cand_v[p]) begin
        if (fill[ws_d] < DEPTH) begin
          ok = 1'b1;
        end else if (fill[~ws_d] < DEPTH) begin
          tgt  = ~ws_d;
          ws_d = ~ws_d;
          ok   = 1'b1;
        end else begin
          ovf = 1'b1;
        end
      end
      if (ok) begin
        if (!q_wa[tgt]) begin
          q_wa[tgt] = 1'b1;
          q_da[tgt] = cand_e[p];
        end else begin
          q_wb[tgt] = 1'b1;
          q_db[tgt] = cand_e[p];
        end
        fill[tgt] = fill[tgt] + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= Q_UPPER;
      rs_q      <= Q_UPPER;
      out_vld_q <= '0;
      out_hi_q  <= '0;
      out_id_q  <= '0;
      lost_q    <= 1'b0;
    end else begin
      ws_q      <= ws_d;
      rs_q      <= rs_d;
      out_vld_q <= lane_v_d;
      out_hi_q  <= lane_hi_d;
      out_id_q  <= lane_id_d;
      lost_q    <= ovf | drop[0] | drop[1];
    end
  end

  assign out_vld  = out_vld_q;
  assign out_hi   = out_hi_q;
  assign out_id   = out_id_q;
  assign out_lost = lost_q;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_chk
    // R10
    flt_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_flt[i] |=> !out_vld[i]);
  end
endmodule

// File: tb/rtr_contention_core_tb_top.sv
`timescale 1ns/1ps
module rtr_contention_core_tb_top;
  localparam int STAGE = 1;
  localparam int TAG_W = 3;
  localparam int ID_W  = 8;
  localparam int DEPTH = 4;
  localparam int MC_N  = 2;
  localparam int CNT_W = $clog2(MC_N + 1);
  localparam int SBIT  = TAG_W - 1 - STAGE;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [1:0]              b_vld, b_hi, b_bc, b_mc;
  logic [2*ID_W-1:0]       b_id;
  logic [2*TAG_W-1:0]      b_tag;
  logic [2*CNT_W-1:0]      b_mcnt;
  logic [2*MC_N*TAG_W-1:0] b_mlist;
  logic [3:0]              b_flt;
  logic [3:0]              out_vld, out_hi;
  logic [4*ID_W-1:0]       out_id;
  logic                    out_lost;

  logic [3:0]        exp_vld, exp_hi;
  logic [4*ID_W-1:0] exp_id;
  logic              exp_lost;
  int                qu[$], ql[$];
  int                m_ws, m_rs;
  int                n_chk, n_bad;
  bit                done;
  string             cur_req;

  always #2.5 clk = ~clk;

  rtr_contention_core #(.STAGE(STAGE), .TAG_W(TAG_W), .ID_W(ID_W), .DEPTH(DEPTH), .MC_N(MC_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(b_vld), .in_hi(b_hi), .in_bc(b_bc), .in_mc(b_mc),
    .in_id(b_id), .in_tag(b_tag), .in_mcnt(b_mcnt), .in_mlist(b_mlist), .lane_flt(b_flt),
    .out_vld(out_vld), .out_hi(out_hi), .out_id(out_id), .out_lost(out_lost));

  function automatic int bw(int p);
    int r;
    if (!b_vld[p]) return 0;
    if (b_bc[p] && STAGE != 0) return 3;
    if (b_mc[p]) begin
      r = 0;
      for (int k = 0; k < int'(b_mcnt[p*CNT_W +: CNT_W]); k++)
        r |= b_mlist[(p*MC_N + k)*TAG_W + SBIT] ? 2 : 1;
      return r;
    end
    return b_tag[p*TAG_W + SBIT] ? 2 : 1;
  endfunction

  task automatic place(int lane, int id, int hi);
    exp_vld[lane] = 1'b1;
    exp_hi[lane]  = hi[0];
    exp_id[lane*ID_W +: ID_W] = ID_W'(id);
  endtask

  task automatic model_step();
    int m[2], sid[2], shi[2], sm[2], left[2], sz[2], cand[2];
    bit cv[2];
    bit qany;
    int pq, e, r0, r1, w, t;
    exp_vld = '0; exp_hi = '0; exp_id = '0; exp_lost = 1'b0;
    for (int p = 0; p < 2; p++) begin m[p] = bw(p); left[p] = 0; end
    sz[0] = qu.size(); sz[1] = ql.size();
    qany = (sz[0] > 0) || (sz[1] > 0);
    pq = 0;
    if (qany) begin
      pq = (sz[m_rs] > 0) ? m_rs : 1 - m_rs;
      m_rs = pq;
      e = (pq == 0) ? qu[0] : ql[0];
      sid[0] = e >> 3; shi[0] = (e >> 2) & 1; sm[0] = e & 3;
      sid[1] = 0; shi[1] = 0; sm[1] = 0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        sid[p] = int'(b_id[p*ID_W +: ID_W]); shi[p] = int'(b_hi[p]); sm[p] = m[p];
      end
    end
    for (int s = 0; s < 2; s++) begin
      r0 = (sm[0] >> s) & 1;
      r1 = (sm[1] >> s) & 1;
      if (r0 == 1 || r1 == 1) begin
        w = (r0 == 1 && r1 == 1) ? ((shi[1] == 1 && shi[0] == 0) ? 1 : 0) : r1;
        if (!b_flt[s])        place(s, sid[w], shi[w]);
        else if (!b_flt[s+2]) place(s + 2, sid[w], shi[w]);
        else                  exp_lost = 1'b1;
        if (r0 == 1 && r1 == 1) begin
          if (!b_flt[s] && !b_flt[s+2]) place(s + 2, sid[1-w], shi[1-w]);
          else left[1-w] |= (1 << s);
        end
      end
    end
    for (int p = 0; p < 2; p++) begin
      if (qany) begin
        cv[p] = (m[p] != 0);
        cand[p] = (int'(b_id[p*ID_W +: ID_W]) << 3) | (int'(b_hi[p]) << 2) | m[p];
      end else begin
        cv[p] = (left[p] != 0);
        cand[p] = (sid[p] << 3) | (shi[p] << 2) | left[p];
      end
    end
    for (int p = 0; p < 2; p++) begin
      if (cv[p]) begin
        t = m_ws;
        if (sz[t] >= DEPTH) begin
          if (sz[1-t] < DEPTH) begin t = 1 - t; m_ws = t; end
          else begin exp_lost = 1'b1; t = -1; end
        end
        if (t == 0) begin qu.push_back(cand[p]); sz[0]++; end
        if (t == 1) begin ql.push_back(cand[p]); sz[1]++; end
      end
    end
    if (qany) begin
      if (pq == 0) void'(qu.pop_front());
      else         void'(ql.pop_front());
    end
  endtask

  task automatic check();
    bit bad;
    n_chk++;
    bad = (out_vld !== exp_vld) || (out_lost !== exp_lost);
    for (int i = 0; i < 4; i++)
      if (exp_vld[i])
        bad |= (out_id[i*ID_W +: ID_W] !== exp_id[i*ID_W +: ID_W]) || (out_hi[i] !== exp_hi[i]);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: vld=%b id=%h hi=%b lost=%b expected vld=%b id=%h hi=%b lost=%b",
               cur_req, out_vld, out_id, out_hi, out_lost, exp_vld, exp_id, exp_hi, exp_lost);
    end
  endtask

  task automatic clr();
    b_vld = '0; b_hi = '0; b_bc = '0; b_mc = '0;
    b_id = '0; b_tag = '0; b_mcnt = '0; b_mlist = '0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check();
    clr();
  endtask

  task automatic put(int p, int hi, int tag, int id);
    b_vld[p] = 1'b1; b_hi[p] = hi[0]; b_bc[p] = 1'b0; b_mc[p] = 1'b0;
    b_tag[p*TAG_W +: TAG_W] = TAG_W'(tag);
    b_id[p*ID_W +: ID_W] = ID_W'(id);
  endtask

  task automatic put_bc(int p, int hi, int id);
    put(p, hi, 0, id);
    b_bc[p] = 1'b1;
  endtask

  task automatic put_mc(int p, int hi, int id, int cnt, int a0, int a1);
    put(p, hi, 0, id);
    b_mc[p] = 1'b1;
    b_mcnt[p*CNT_W +: CNT_W] = CNT_W'(cnt);
    b_mlist[(p*MC_N)*TAG_W +: TAG_W]     = TAG_W'(a0);
    b_mlist[(p*MC_N + 1)*TAG_W +: TAG_W] = TAG_W'(a1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int id;
    n_chk = 0; n_bad = 0; done = 1'b0;
    m_ws = 0; m_rs = 0;
    clr();
    b_flt = '0;
    rst_n = 1'b0;
    exp_vld = '0; exp_hi = '0; exp_id = '0; exp_lost = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check();
    rst_n = 1'b1;
    tick();

    cur_req = "R2";
    put(0, 0, 3'b000, 8'h11); tick();
    put(1, 1, 3'b010, 8'h12); tick();
    put(0, 0, 3'b010, 8'h13); put(1, 0, 3'b101, 8'h14); tick();

    cur_req = "R4";
    put(0, 0, 3'b000, 8'h21); put(1, 0, 3'b000, 8'h22); tick();
    put(0, 1, 3'b010, 8'h23); put(1, 1, 3'b010, 8'h24); tick();

    cur_req = "R3";
    put(0, 0, 3'b000, 8'h31); put(1, 1, 3'b000, 8'h32); tick();
    put(0, 1, 3'b010, 8'h33); put(1, 0, 3'b010, 8'h34); tick();

    cur_req = "R10";
    b_flt = 4'b0001;
    put(0, 0, 3'b000, 8'h41); tick();
    b_flt = 4'b0101;
    put(1, 1, 3'b000, 8'h42); tick();
    b_flt = 4'b0000;
    tick();

    cur_req = "R5";
    b_flt = 4'b0100;
    put(0, 0, 3'b000, 8'h51); put(1, 1, 3'b000, 8'h52); tick();
    cur_req = "R6";
    put(0, 1, 3'b010, 8'h53); tick();
    tick();
    tick();
    b_flt = 4'b0000;

    cur_req = "R7/R8/R9";
    b_flt = 4'b1100;
    put(0, 0, 3'b000, 8'h60); put(1, 1, 3'b000, 8'h61); tick();
    for (int n = 0; n < 10; n++) begin
      put(0, n % 2, 3'b000, 8'h62 + 2*n); put(1, 0, 3'b010, 8'h63 + 2*n); tick();
    end
    for (int n = 0; n < 14; n++) tick();
    b_flt = 4'b0000;

    cur_req = "R11";
    put_bc(0, 0, 8'h71); tick();
    put_bc(0, 0, 8'h72); put_bc(1, 1, 8'h73); tick();
    put_bc(1, 0, 8'h74); b_mc[1] = 1'b1; tick();

    cur_req = "R12";
    put_mc(0, 0, 8'h81, 2, 3'b000, 3'b010); tick();
    put_mc(1, 1, 8'h82, 2, 3'b000, 3'b001); tick();
    put_mc(0, 0, 8'h83, 1, 3'b010, 3'b000); tick();
    put_mc(1, 0, 8'h84, 0, 3'b010, 3'b000); tick();

    cur_req = "R2/R3/R5/R6/R10 mixed";
    id = 8'h90;
    for (int n = 0; n < 600; n++) begin
      for (int p = 0; p < 2; p++) begin
        if ($urandom_range(0, 3) != 0) begin
          case ($urandom_range(0, 7))
            0:       put_bc(p, $urandom_range(0, 1), id);
            1:       put_mc(p, $urandom_range(0, 1), id, $urandom_range(0, 2),
                            $urandom_range(0, 7), $urandom_range(0, 7));
            default: put(p, $urandom_range(0, 1), $urandom_range(0, 7), id);
          endcase
          id = (id + 1) & 8'hff;
        end
      end
      b_flt = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
      tick();
    end
    b_flt = 4'b0000;
    for (int n = 0; n < 20; n++) tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule